// File: doc/BRIEF.md
# Byte/Word Adder with Status Flag Register

This block adds two operands in either byte or word width, with an optional incoming carry for multi-precision chains. Alongside the sum, it works out six condition bits: carry, parity, half carry, zero, sign and signed overflow. The sum is available combinationally in the same cycle as its operands.

A 16-bit flag register keeps the most recent condition bits. It captures them only on cycles where the arithmetic strobe is high. The same register holds three control bits: single-step trap, interrupt enable and string direction. Each of these can be set or cleared on its own through dedicated strobe inputs, and arithmetic never touches them. Every bit position not listed below is hardwired to zero.

Top module: `status_adder`

## Requirements
- R1: In word mode (`wide`=1), `sum` equals (`op_a`+`op_b`+`carry_in`) mod 2^16. In byte mode (`wide`=0), `sum[7:0]` equals (`op_a[7:0]`+`op_b[7:0]`+`carry_in`) mod 256 and `sum[15:8]` is zero.
- R2: Flag bit 0 (carry) is the carry out of the top bit of the selected width.
- R3: Flag bit 5 (overflow) is set when the result, read as two's complement, lies outside the signed range of the selected width.
- R4: Flag bit 4 (sign) equals the top bit of the selected-width result. Flag bit 3 (zero) is set when the selected-width result is all zeros.
- R5: Flag bit 2 (half carry) is set when the addition carries from bit 3 into bit 4.
- R6: Flag bit 1 (parity) is set when `sum[7:0]` holds an even number of ones, in both widths.
- R7: When `arith_en` is high at a rising clock edge, flag bits 5:0 take the values for the current operands after that edge. When `arith_en` is low, they hold.
- R8: Control bits sit at flag bit 8 (trap), bit 9 (interrupt enable) and bit 10 (direction). They map to index 0, 1 and 2 of `ctl_set` and `ctl_clr`. A set or clear strobe acts at the next edge. If set and clear are both high for the same bit, clear wins. A control bit holds when neither strobe is high, and arithmetic has no effect on it.
- R9: Flag bits 15:11 and 7:6 always read zero.
- R10: While `rst_n` is low, the whole flag register is zero.
- R11: In byte mode with no incoming carry, 38h+2Fh gives 67h with carry 0, parity 0, half carry 1, zero 0 and sign 0. Likewise 9Ch+64h gives 00h with carry 1, parity 1, half carry 1, zero 1 and sign 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Incoming carry added to the sum |
| wide | input | 1 | 1 selects word width, 0 selects byte width |
| arith_en | input | 1 | Capture condition bits at this edge |
| ctl_set | input | 3 | Per-bit set strobes for trap, interrupt enable, direction |
| ctl_clr | input | 3 | Per-bit clear strobes, same ordering |
| sum | output | 16 | Combinational sum |
| flags | output | 16 | Flag register |

## Verification
The properties assume that operands, width and strobes are stable around the rising edge and change only between edges. The bench meets this by driving every input on the falling edge. The properties also assume that byte-mode results carry nothing in the upper byte, so the zero-bit property can compare against the full `sum` word. Stimulus never pulses a control strobe in the same cycle as an arithmetic capture it wants to check in isolation, except in the one deliberate case that shows arithmetic leaves the control bits alone.

// File: rtl/flagadd_pkg.sv
// Shared widths, flag bit positions and the condition-bit bundle.
// Assumes a single flag register layout used by all submodules.
package flagadd_pkg;
    localparam int DATA_W   = 16;
    localparam int NARROW_W = 8;
    localparam int FLAG_W   = 16;
    localparam int PAR_W    = 8;
    localparam int NUM_CTL  = 3;

    localparam int CF_BIT = 0;
    localparam int PF_BIT = 1;
    localparam int AF_BIT = 2;
    localparam int ZF_BIT = 3;
    localparam int SF_BIT = 4;
    localparam int OF_BIT = 5;
    localparam int TF_BIT = 8;
    localparam int IE_BIT = 9;
    localparam int DF_BIT = 10;

    // Packed so that bit k lands on flag bit k (overflow is bit 5).
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } status_t;

    localparam int STAT_W = $bits(status_t);
endpackage

// File: rtl/add_core.sv
// Adder datapath: forms the byte or word sum plus carry, half carry and
// signed overflow. Assumes NARROW_W >= 5 so the nibble boundary exists.
module add_core
    import flagadd_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int NW = NARROW_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         wide,
    output logic [W-1:0] sum,
    output logic         cry,
    output logic         aux,
    output logic         ovf
);
    logic [W:0]  wide_ext;
    logic [NW:0] nar_ext;
    logic [4:0]  nib_ext;
    logic        a_top, b_top, s_top;

    // Full-width and narrow-width sums with carry out.
    always_comb begin
        wide_ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        nar_ext  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        nib_ext  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cin};
    end

    // Width selection of result, carry and sign-overflow inputs.
    always_comb begin
        if (wide) begin
            sum   = wide_ext[W-1:0];
            cry   = wide_ext[W];
            a_top = a[W-1];
            b_top = b[W-1];
            s_top = wide_ext[W-1];
        end else begin
            sum   = {{(W-NW){1'b0}}, nar_ext[NW-1:0]};
            cry   = nar_ext[NW];
            a_top = a[NW-1];
            b_top = b[NW-1];
            s_top = nar_ext[NW-1];
        end
        aux = nib_ext[4];
        ovf = (a_top == b_top) && (s_top != a_top);
    end
endmodule

// File: rtl/status_eval.sv
// Derives the six condition bits from the selected-width result.
// Assumes the upper part of sum is zero in narrow mode.
module status_eval
    import flagadd_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int NW = NARROW_W,
    parameter int PW = PAR_W
) (
    input  logic [W-1:0] sum,
    input  logic         wide,
    input  logic         cry,
    input  logic         aux,
    input  logic         ovf,
    output status_t      st
);
    // Bundle zero, sign and low-byte parity with the adder's carries.
    always_comb begin
        st.cry = cry;
        st.aux = aux;
        st.ovf = ovf;
        st.par = ~(^sum[PW-1:0]);
        st.zro = wide ? (sum == '0) : (sum[NW-1:0] == '0);
        st.sgn = wide ? sum[W-1] : sum[NW-1];
    end
endmodule

// File: rtl/flag_reg.sv
// Flag register: condition bits load on upd, control bits are set or
// cleared individually (clear wins), all other bits read zero.
module flag_reg
    import flagadd_pkg::*;
#(
    parameter int FW = FLAG_W,
    parameter int NC = NUM_CTL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  status_t       st,
    input  logic [NC-1:0] ctl_set,
    input  logic [NC-1:0] ctl_clr,
    output logic [FW-1:0] flags
);
    localparam int CTL_POS [NUM_CTL] = '{TF_BIT, IE_BIT, DF_BIT};

    status_t       stat_q;
    logic [NC-1:0] ctl_q;

    // Condition bits capture only on the arithmetic strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   stat_q <= '0;
        else if (upd) stat_q <= st;
    end

    for (genvar i = 0; i < NC; i++) begin : g_ctl
        // One control bit: clear has priority over set.
        always_ff @(posedge clk) begin
            if (!rst_n)          ctl_q[i] <= 1'b0;
            else if (ctl_clr[i]) ctl_q[i] <= 1'b0;
            else if (ctl_set[i]) ctl_q[i] <= 1'b1;
        end
    end

    // Assemble the visible register with reserved positions at zero.
    always_comb begin
        flags = '0;
        flags[STAT_W-1:0] = stat_q;
        for (int k = 0; k < NC; k++) flags[CTL_POS[k]] = ctl_q[k];
    end
endmodule

// File: rtl/status_adder.sv
// Top: byte/word adder with condition bits and a 16-bit flag register.
// Assumes inputs are stable around the rising edge.
module status_adder
    import flagadd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    op_a,
    input  logic [DATA_W-1:0]    op_b,
    input  logic                 carry_in,
    input  logic                 wide,
    input  logic                 arith_en,
    input  logic [NUM_CTL-1:0]   ctl_set,
    input  logic [NUM_CTL-1:0]   ctl_clr,
    output logic [DATA_W-1:0]    sum,
    output logic [FLAG_W-1:0]    flags
);
    logic    cry, aux, ovf;
    status_t st;

    add_core #(.W(DATA_W), .NW(NARROW_W)) u_core (
        .a(op_a), .b(op_b), .cin(carry_in), .wide(wide),
        .sum(sum), .cry(cry), .aux(aux), .ovf(ovf)
    );

    status_eval #(.W(DATA_W), .NW(NARROW_W), .PW(PAR_W)) u_eval (
        .sum(sum), .wide(wide), .cry(cry), .aux(aux), .ovf(ovf), .st(st)
    );

    flag_reg #(.FW(FLAG_W), .NC(NUM_CTL)) u_flags (
        .clk(clk), .rst_n(rst_n), .upd(arith_en), .st(st),
        .ctl_set(ctl_set), .ctl_clr(ctl_clr), .flags(flags)
    );
endmodule

// File: rtl/status_adder_chk.sv
// Checker bound to status_adder: temporal rules on the flag register.
// Assumes inputs change only between rising edges.
module status_adder_chk
    import flagadd_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wide,
    input logic                 arith_en,
    input logic [NUM_CTL-1:0]   ctl_set,
    input logic [NUM_CTL-1:0]   ctl_clr,
    input logic [DATA_W-1:0]    sum,
    input logic [FLAG_W-1:0]    flags
);
    localparam logic [FLAG_W-1:0] RES_MASK = 16'hF8C0;

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & RES_MASK) == '0);

    p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !arith_en |=> $stable(flags[STAT_W-1:0]));

    p_ctl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set == '0 && ctl_clr == '0) |=> $stable(flags[DF_BIT:TF_BIT]));

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clr[0] |=> !flags[TF_BIT]);

    p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arith_en |=> flags[ZF_BIT] == ($past(sum) == '0));

    p_sign_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arith_en && !wide) |=> flags[SF_BIT] == $past(sum[NARROW_W-1]));

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> sum[DATA_W-1:NARROW_W] == '0);
endmodule

bind status_adder status_adder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wide(wide), .arith_en(arith_en),
    .ctl_set(ctl_set), .ctl_clr(ctl_clr), .sum(sum), .flags(flags)
);

// File: tb/status_adder_tb_top.sv
module status_adder_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic        carry_in = 1'b0, wide = 1'b0, arith_en = 1'b0;
    logic [2:0]  ctl_set = '0, ctl_clr = '0;
    logic [15:0] sum, flags;

    int checks = 0;
    int fails  = 0;
    logic [2:0] ctl_exp = '0;

    status_adder dut_i (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .wide(wide), .arith_en(arith_en),
        .ctl_set(ctl_set), .ctl_clr(ctl_clr), .sum(sum), .flags(flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] full_flags(input logic [5:0] st);
        logic [15:0] f = '0;
        f[5:0] = st;
        f[10:8] = ctl_exp;
        return f;
    endfunction

    // Apply one addition with capture; check sum then flag register.
    task automatic run_add(input logic [15:0] a, input logic [15:0] b, input bit w, input bit c);
        int msk, wdt, ua, ub, r, sa, sb, sr, lim;
        logic [15:0] s_exp;
        logic [5:0] st;
        wdt = w ? 16 : 8;
        msk = (1 << wdt) - 1;
        lim = 1 << (wdt - 1);
        ua = int'(a) & msk;
        ub = int'(b) & msk;
        r = ua + ub + int'(c);
        s_exp = 16'(r & msk);
        sa = (ua >= lim) ? ua - 2*lim : ua;
        sb = (ub >= lim) ? ub - 2*lim : ub;
        sr = sa + sb + int'(c);
        st[0] = (r > msk);                                  // R2
        st[1] = ($countones(s_exp[7:0]) % 2) == 0;           // R6
        st[2] = ((ua & 15) + (ub & 15) + int'(c)) > 15;       // R5
        st[3] = (s_exp == 0);                                // R4
        st[4] = s_exp[wdt-1];                                // R4
        st[5] = (sr >= lim) || (sr < -lim);                  // R3
        @(negedge clk);
        op_a = a; op_b = b; wide = w; carry_in = c; arith_en = 1'b1;
        #1;
        chk(sum == s_exp, "R1 sum", sum, s_exp);
        @(posedge clk);
        #1;
        arith_en = 1'b0;
        chk(flags[5:0] == st, "R2 R3 R4 R5 R6 R7 condition bits", {10'd0, flags[5:0]}, {10'd0, st});
        chk(flags == full_flags(st), "R8 R9 whole register", flags, full_flags(st));
    endtask

    task automatic ctl_op(input logic [2:0] s, input logic [2:0] c);
        @(negedge clk);
        ctl_set = s; ctl_clr = c;
        @(negedge clk);
        ctl_set = '0; ctl_clr = '0;
        ctl_exp = (ctl_exp | s) & ~c;
    endtask

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        chk(flags == 16'h0000, "R10 reset value", flags, 16'h0000);
        // Reset holds the register at zero even with strobes active.
        ctl_set = 3'b111; arith_en = 1'b1; op_a = 16'h00FF; op_b = 16'h0001;
        @(negedge clk);
        chk(flags == 16'h0000, "R10 held in reset", flags, 16'h0000);
        ctl_set = '0; arith_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R11 worked examples.
        run_add(16'h0038, 16'h002F, 1'b0, 1'b0);
        chk(flags[5:0] == 6'b000100, "R11 38h+2Fh", {10'd0, flags[5:0]}, 16'h0004);
        run_add(16'h009C, 16'h0064, 1'b0, 1'b0);
        chk(flags[4:0] == 5'b01111, "R11 9Ch+64h", {11'd0, flags[4:0]}, 16'h000F);

        // Word corners (R1 R2 R3 R6 parity of low byte only).
        run_add(16'h7FFF, 16'h0001, 1'b1, 1'b0);
        run_add(16'hFFFF, 16'h0001, 1'b1, 1'b0);
        run_add(16'h8000, 16'h8000, 1'b1, 1'b0);
        run_add(16'hFFFF, 16'hFFFF, 1'b1, 1'b1);
        run_add(16'h0100, 16'h0200, 1'b1, 1'b0);
        // Byte mode ignores upper operand bits (R1).
        run_add(16'hAB7F, 16'hCD01, 1'b0, 1'b0);

        // R8 control bits: set, clear wins, arithmetic leaves them.
        ctl_op(3'b101, 3'b000);
        chk(flags[10:8] == 3'b101, "R8 set", {13'd0, flags[10:8]}, 16'h0005);
        ctl_op(3'b011, 3'b001);
        chk(flags[10:8] == 3'b110, "R8 clear wins", {13'd0, flags[10:8]}, 16'h0006);
        held = flags;
        ctl_op(3'b000, 3'b000);
        chk(flags == held, "R8 hold", flags, held);
        run_add(16'h00FF, 16'h0001, 1'b0, 1'b0);
        chk(flags[10:8] == 3'b110, "R8 arith no effect", {13'd0, flags[10:8]}, 16'h0006);

        // R7: no capture when the strobe is low.
        held = flags;
        @(negedge clk);
        op_a = 16'h1234; op_b = 16'h4321; wide = 1'b1; arith_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(flags == held, "R7 hold without strobe", flags, held);

        // Exhaustive byte sweep, carry_in alternating.
        for (int i = 0; i < 256; i++)
            for (int j = 0; j < 256; j++)
                run_add(16'(i), 16'(j), 1'b0, 1'((i ^ j) & 1));

        // Word sweep of random patterns.
        for (int k = 0; k < 3000; k++)
            run_add(16'($urandom()), 16'($urandom()), 1'b1, 1'($urandom() & 1));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule